// File: doc/BRIEF.md
# Two-Channel Chained-Descriptor DMA Engine

This block copies words from one memory region to another with no processor involvement. It has two channels. Software programs each channel through a small register port. A channel holds a source address, a destination address, a pointer to the next descriptor, a control word and a configuration word. Setting the enable bit in the configuration word starts the channel. The engine then reads one word from the source and writes it to the destination. It repeats this until the word count in the control word reaches zero.

When a block ends, the channel reads the next-descriptor pointer. A non-zero pointer makes the engine fetch a four-word descriptor from memory and carry on with the new block. A zero pointer makes the channel stop and clear its enable bit. Block completion and bus faults set sticky per-channel flags. Each flag is visible in raw form and in masked form. Software removes a flag by writing ones to a write-only clear register.

The master side is a valid/ready request port. The engine raises `m_valid` and holds `m_addr`, `m_write` and `m_wdata` steady until it sees `m_ready`. A transfer completes in the cycle where both are high. In that cycle the memory returns `m_rdata` for reads and `m_err` for a fault. While `m_ready` is low the engine simply waits.

Top module: `dmac2_ll`

## Requirements
- R1: After reset, every readable register returns 0, `m_valid` is low and `irq` is low.
- R2: Channel c has a register window at 0x100 + 0x20*c. Within it, source is at +0x00, destination at +0x04, next pointer at +0x08, control at +0x0C and configuration at +0x10. Each of these reads back the value written.
- R3: Writing the configuration with bit 0 set starts the channel. For a count N in control bits 11:0, the engine reads source address s+4k and then writes that word to destination d+4k, for k = 0..N-1. Afterwards the source and destination registers read s+4N and d+4N, and the count field reads 0.
- R4: The engine re-arbitrates after every word. Whenever both channels are enabled, channel 0 wins. A transfer already offered on the bus is always finished first.
- R5: At the end of a block with a non-zero next pointer p, the engine reads p, p+4, p+8 and p+12. These words load the source, destination, next pointer and control in that order, and the new block then runs. At the end of a block with a zero pointer, configuration bit 0 clears and the bus stays idle.
- R6: A block end sets raw terminal-count bit c (global 0x14) only when control bit 31 is set. The terminal-count status (0x04) equals that raw bit ANDed with configuration bit 15.
- R7: A transfer completed with `m_err` high sets raw error bit c (0x18) and clears configuration bit 0. That channel then makes no further bus requests. The error status (0x0C) equals the raw bit ANDed with configuration bit 14.
- R8: Writing 0x08 clears the raw terminal-count bits that are 1 in the written data. Writing 0x10 does the same for the raw error bits. Bits written as 0 are untouched, and both clear registers read 0.
- R9: Bit c of the combined status (0x00) is channel c's masked terminal-count OR masked error bit. `irq` is high when any combined bit is set.
- R10: Once `m_valid` is high it stays high, with `m_addr`, `m_write` and `m_wdata` unchanged, until the cycle in which `m_ready` is high.
- R11: Enabling a channel whose count field is 0 ends the block at once, with no source or destination transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on reg_addr) |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Memory accepts the request this cycle |
| m_write | output | 1 | Request is a write |
| m_addr | output | DW | Request byte address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, valid with m_ready |
| m_err | input | 1 | Fault response, valid with m_ready |
| irq | output | 1 | Any enabled interrupt pending |

## Verification
The bench uses the default parameters: a 12-bit count field, a 9-bit register address and a 32-bit data path. It keeps blocks to zero to three words, so one short run reaches the empty-block path, a two-block chain, a stalled priority contention and a fault in mid-block. A memory model with a periodic `m_ready` stall drives the master port. Every handshake is compared against a queue of transfers worked out from the register settings.

// File: rtl/dmac2_pkg.sv
package dmac2_pkg;
  localparam int NCH    = 2;
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int WIN_SH = 5;

  // global register word indices
  localparam logic [2:0] GI_ANY    = 3'd0;
  localparam logic [2:0] GI_TC     = 3'd1;
  localparam logic [2:0] GI_TCCLR  = 3'd2;
  localparam logic [2:0] GI_ERR    = 3'd3;
  localparam logic [2:0] GI_ERRCLR = 3'd4;
  localparam logic [2:0] GI_RAWTC  = 3'd5;
  localparam logic [2:0] GI_RAWERR = 3'd6;

  // channel register word indices
  localparam logic [2:0] CI_SRC  = 3'd0;
  localparam logic [2:0] CI_DST  = 3'd1;
  localparam logic [2:0] CI_NEXT = 3'd2;
  localparam logic [2:0] CI_CTL  = 3'd3;
  localparam logic [2:0] CI_CFG  = 3'd4;

  localparam int CFG_EN   = 0;
  localparam int CFG_ERRM = 14;
  localparam int CFG_TCM  = 15;
  localparam int CTL_TCIE = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_DONE, ST_LD
  } dmac_st_e;
endpackage

// File: rtl/dmac2_chan.sv
module dmac2_chan #(
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [2:0]    sw_idx,
  input  logic [DW-1:0] sw_wdata,
  input  logic          step,
  input  logic          ld_en,
  input  logic [1:0]    ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          stop,
  output logic [DW-1:0] src,
  output logic [DW-1:0] dst,
  output logic [DW-1:0] nxt,
  output logic [DW-1:0] ctl,
  output logic [DW-1:0] cfg
);
  import dmac2_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; nxt <= '0; ctl <= '0; cfg <= '0;
    end else begin
      if (step) begin
        src <= src + DW'(4);
        dst <= dst + DW'(4);
        ctl[CNT_W-1:0] <= ctl[CNT_W-1:0] - CNT_W'(1);
      end
      if (ld_en) begin
        case (ld_idx)
          2'd0: src <= ld_data;
          2'd1: dst <= ld_data;
          2'd2: nxt <= ld_data;
          default: ctl <= ld_data;
        endcase
      end
      if (stop) cfg[CFG_EN] <= 1'b0;
      if (sw_we) begin
        case (sw_idx)
          CI_SRC:  src <= sw_wdata;
          CI_DST:  dst <= sw_wdata;
          CI_NEXT: nxt <= sw_wdata;
          CI_CTL:  ctl <= sw_wdata;
          CI_CFG:  cfg <= sw_wdata;
          default: ;
        endcase
      end
    end
  end

  AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sw_we) |=> (ctl[CNT_W-1:0] == $past(ctl[CNT_W-1:0]) - CNT_W'(1))); // R3
endmodule

// File: rtl/dmac2_arb.sv
module dmac2_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb gnt = req & ~(req - N'(1));

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_CH0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]); // R4
endmodule

// File: rtl/dmac2_irq.sv
module dmac2_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tc_set,
  input  logic [N-1:0] err_set,
  input  logic         tc_clr_we,
  input  logic         err_clr_we,
  input  logic [N-1:0] clr_data,
  input  logic [N-1:0] tc_mask,
  input  logic [N-1:0] err_mask,
  output logic [N-1:0] raw_tc,
  output logic [N-1:0] raw_err,
  output logic [N-1:0] st_tc,
  output logic [N-1:0] st_err,
  output logic [N-1:0] st_any,
  output logic         irq
);
  logic [N-1:0] tc_kill, err_kill;

  always_comb begin
    tc_kill  = tc_clr_we  ? clr_data : '0;
    err_kill = err_clr_we ? clr_data : '0;
    st_tc    = raw_tc & tc_mask;
    st_err   = raw_err & err_mask;
    st_any   = st_tc | st_err;
    irq      = |st_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
    end else begin
      raw_tc  <= (raw_tc & ~tc_kill) | tc_set;
      raw_err <= (raw_err & ~err_kill) | err_set;
    end
  end

  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_clr_we |=> ((raw_tc & $past(raw_tc)) == $past(raw_tc))); // R8
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((raw_err & $past(err_set)) == $past(err_set))); // R7
endmodule

// File: rtl/dmac2_ll.sv
module dmac2_ll #(
  parameter int REG_AW = 9,
  parameter int DW     = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [DW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_err,
  output logic              irq
);
  import dmac2_pkg::*;

  localparam int CH_LO = WIN_SH + CHW;

  logic [DW-1:0] c_src [NCH];
  logic [DW-1:0] c_dst [NCH];
  logic [DW-1:0] c_nxt [NCH];
  logic [DW-1:0] c_ctl [NCH];
  logic [DW-1:0] c_cfg [NCH];

  logic [NCH-1:0] step_v, stop_v, ld_v, tc_set, err_set, req, gnt;
  logic [NCH-1:0] tc_mask, err_mask, raw_tc, raw_err, st_tc, st_err, st_any, cur_oh;
  logic [CHW-1:0] cur, gidx, rch;
  logic [2:0]     widx;
  logic           in_chan, chan_ok, glob_ok, tc_clr_we, err_clr_we;
  dmac_st_e       st;
  logic [DW-1:0]  data_q, next_q;
  logic [1:0]     ld_idx;

  // register port decode
  always_comb begin
    in_chan    = reg_addr[REG_AW-1];
    widx       = reg_addr[4:2];
    rch        = reg_addr[WIN_SH +: CHW];
    chan_ok    = in_chan && (reg_addr[REG_AW-2:CH_LO] == '0);
    glob_ok    = !in_chan && (reg_addr[REG_AW-2:WIN_SH] == '0);
    tc_clr_we  = reg_we && glob_ok && (widx == GI_TCCLR);
    err_clr_we = reg_we && glob_ok && (widx == GI_ERRCLR);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac2_chan #(.DW(DW), .CNT_W(CNT_W)) u_chan (
      .clk, .rst_n,
      .sw_we   (reg_we && chan_ok && (rch == CHW'(g))),
      .sw_idx  (widx),
      .sw_wdata(reg_wdata),
      .step    (step_v[g]),
      .ld_en   (ld_v[g]),
      .ld_idx  (ld_idx),
      .ld_data (m_rdata),
      .stop    (stop_v[g]),
      .src     (c_src[g]),
      .dst     (c_dst[g]),
      .nxt     (c_nxt[g]),
      .ctl     (c_ctl[g]),
      .cfg     (c_cfg[g])
    );
    assign req[g]      = c_cfg[g][CFG_EN];
    assign tc_mask[g]  = c_cfg[g][CFG_TCM];
    assign err_mask[g] = c_cfg[g][CFG_ERRM];
  end

  dmac2_arb #(.N(NCH)) u_arb (.clk, .rst_n, .req, .gnt);

  dmac2_irq #(.N(NCH)) u_irq (
    .clk, .rst_n, .tc_set, .err_set, .tc_clr_we, .err_clr_we,
    .clr_data(reg_wdata[NCH-1:0]), .tc_mask, .err_mask,
    .raw_tc, .raw_err, .st_tc, .st_err, .st_any, .irq
  );

  always_comb begin
    gidx = '0;
    for (int i = NCH - 1; i >= 0; i--) if (gnt[i]) gidx = CHW'(i);
    cur_oh = NCH'(1) << cur;
  end

  // bus master and per-channel update strobes
  always_comb begin
    step_v = '0; stop_v = '0; ld_v = '0; tc_set = '0; err_set = '0;
    m_valid = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = data_q;
    case (st)
      ST_RD: begin
        m_valid = 1'b1;
        m_addr  = c_src[cur];
        if (m_ready && m_err) begin err_set[cur] = 1'b1; stop_v[cur] = 1'b1; end
      end
      ST_WR: begin
        m_valid = 1'b1;
        m_write = 1'b1;
        m_addr  = c_dst[cur];
        if (m_ready) begin
          if (m_err) begin err_set[cur] = 1'b1; stop_v[cur] = 1'b1; end
          else step_v[cur] = 1'b1;
        end
      end
      ST_DONE: begin
        tc_set[cur] = c_ctl[cur][CTL_TCIE];
        if (c_nxt[cur] == '0) stop_v[cur] = 1'b1;
      end
      ST_LD: begin
        m_valid = 1'b1;
        m_addr  = next_q + DW'({ld_idx, 2'b00});
        if (m_ready) begin
          if (m_err) begin err_set[cur] = 1'b1; stop_v[cur] = 1'b1; end
          else ld_v[cur] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cur <= '0; data_q <= '0; next_q <= '0; ld_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (|req) begin
          cur <= gidx;
          st  <= (c_ctl[gidx][CNT_W-1:0] == '0) ? ST_DONE : ST_RD;
        end
        ST_RD: if (m_ready) begin
          if (m_err) st <= ST_IDLE;
          else begin data_q <= m_rdata; st <= ST_WR; end
        end
        ST_WR: if (m_ready) begin
          if (m_err) st <= ST_IDLE;
          else st <= (c_ctl[cur][CNT_W-1:0] == CNT_W'(1)) ? ST_DONE : ST_IDLE;
        end
        ST_DONE: begin
          if (c_nxt[cur] == '0) st <= ST_IDLE;
          else begin
            next_q <= {c_nxt[cur][DW-1:2], 2'b00};
            ld_idx <= '0;
            st     <= ST_LD;
          end
        end
        ST_LD: if (m_ready) begin
          if (m_err || ld_idx == 2'd3) st <= ST_IDLE;
          else ld_idx <= ld_idx + 2'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (chan_ok) begin
      case (widx)
        CI_SRC:  reg_rdata = c_src[rch];
        CI_DST:  reg_rdata = c_dst[rch];
        CI_NEXT: reg_rdata = c_nxt[rch];
        CI_CTL:  reg_rdata = c_ctl[rch];
        CI_CFG:  reg_rdata = c_cfg[rch];
        default: ;
      endcase
    end else if (glob_ok) begin
      case (widx)
        GI_ANY:    reg_rdata = DW'(st_any);
        GI_TC:     reg_rdata = DW'(st_tc);
        GI_ERR:    reg_rdata = DW'(st_err);
        GI_RAWTC:  reg_rdata = DW'(raw_tc);
        GI_RAWERR: reg_rdata = DW'(raw_err);
        default: ;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !reg_we) |=>
      (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata))); // R10
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_err && !reg_we) |=> ((req & $past(cur_oh)) == '0)); // R7
  AST_ZERO_PTR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && c_nxt[cur] == '0 && !reg_we) |=> ((req & $past(cur_oh)) == '0)); // R5
endmodule

// File: tb/dmac2_ll_test.sv
module dmac2_ll_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        m_valid, m_write, m_err;
  logic        m_ready = 1'b1;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        irq;

  typedef struct packed { logic [31:0] a; logic w; logic [31:0] d; } txn_t;
  txn_t        exp_q[$];
  txn_t        e;
  logic [31:0] mem [0:255];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic        hold = 1'b0, stall = 1'b0, err_on = 1'b0;
  logic [31:0] err_addr = '0;
  logic        pv_wait = 1'b0;
  logic [31:0] pv_addr = '0;
  logic [31:0] v;

  always #5 clk = ~clk;

  dmac2_ll uut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .m_valid, .m_ready, .m_write, .m_addr, .m_wdata, .m_rdata, .m_err, .irq
  );

  assign m_rdata = mem[m_addr[9:2]];
  assign m_err   = err_on && m_valid && (m_addr == err_addr);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    m_ready = !hold && !(stall && (cyc % 3 == 0));
  end

  // reference comparison on every clock
  always @(posedge clk) if (rst_n) begin
    if (pv_wait) begin
      n_chk++;
      if (!m_valid || m_addr !== pv_addr) begin
        n_fail++;
        $display("FAIL R10 held request actual=%h expected=%h", m_addr, pv_addr);
      end
    end
    pv_wait = m_valid && !m_ready;
    pv_addr = m_addr;
    if (m_valid && m_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected transfer actual=%h expected=none", m_addr);
      end else begin
        e = exp_q.pop_front();
        if (m_addr !== e.a || m_write !== e.w || (e.w && m_wdata !== e.d)) begin
          n_fail++;
          $display("FAIL R3/R4/R5 transfer actual=%h/%0b/%h expected=%h/%0b/%h",
                   m_addr, m_write, m_wdata, e.a, e.w, e.d);
        end
      end
      if (m_write && !m_err) mem[m_addr[9:2]] = m_wdata;
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
    exp_q.push_back({a, w, d});
  endtask

  task automatic copy_exp(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      push(s + 4*k, 1'b0, 32'h0);
      push(d + 4*k, 1'b1, mem[(s >> 2) + k]);
    end
  endtask

  task automatic drain(input string r);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(r, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | (i * 32'h0001_0003);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(9'h000, v); chk("R1 any", v, 0);
    rd(9'h004, v); chk("R1 tc", v, 0);
    rd(9'h014, v); chk("R1 rawtc", v, 0);
    rd(9'h018, v); chk("R1 rawerr", v, 0);
    rd(9'h110, v); chk("R1 cfg0", v, 0);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 irq", irq, 0);

    // R2 register map readback
    wr(9'h120, 32'h0000_0340); wr(9'h124, 32'h0000_0344);
    wr(9'h128, 32'h0000_0348); wr(9'h12C, 32'h0000_0005);
    rd(9'h120, v); chk("R2 src1", v, 32'h340);
    rd(9'h124, v); chk("R2 dst1", v, 32'h344);
    rd(9'h128, v); chk("R2 nxt1", v, 32'h348);
    rd(9'h12C, v); chk("R2 ctl1", v, 32'h5);
    rd(9'h100, v); chk("R2 src0 untouched", v, 0);

    // R3 R6 R9 single block with stalls
    stall = 1'b1;
    wr(9'h100, 32'h40); wr(9'h104, 32'h80); wr(9'h108, 0); wr(9'h10C, 32'h8000_0003);
    copy_exp(32'h40, 32'h80, 3);
    wr(9'h110, 32'h0000_C001);
    drain("R3 block drained");
    rd(9'h110, v); chk("R5 enable cleared", v, 32'hC000);
    rd(9'h10C, v); chk("R3 count zero", v, 32'h8000_0000);
    rd(9'h100, v); chk("R3 src advanced", v, 32'h4C);
    rd(9'h104, v); chk("R3 dst advanced", v, 32'h8C);
    chk("R3 data copied", mem[8'h22], mem[8'h12]);
    rd(9'h014, v); chk("R6 raw tc", v, 1);
    rd(9'h004, v); chk("R6 masked tc", v, 1);
    rd(9'h000, v); chk("R9 combined", v, 1);
    chk("R9 irq", irq, 1);

    // R8 clears
    wr(9'h008, 32'h2);
    rd(9'h014, v); chk("R8 zero bit untouched", v, 1);
    rd(9'h008, v); chk("R8 clear reads zero", v, 0);
    wr(9'h008, 32'h1);
    rd(9'h014, v); chk("R8 tc cleared", v, 0);
    chk("R8 irq low", irq, 0);

    // R11 empty block, tc unmasked off
    wr(9'h10C, 32'h8000_0000);
    wr(9'h110, 32'h1);
    repeat (20) @(negedge clk);
    rd(9'h014, v); chk("R11 raw tc", v, 1);
    rd(9'h004, v); chk("R6 mask blocks", v, 0);
    chk("R9 irq masked", irq, 0);
    rd(9'h110, v); chk("R11 stopped", v, 0);
    wr(9'h008, 32'h1);

    // R4 priority: ch1 offered first, ch0 enabled while bus held
    stall = 1'b0; hold = 1'b1;
    wr(9'h120, 32'hC0); wr(9'h124, 32'hE0); wr(9'h128, 0); wr(9'h12C, 32'h2);
    wr(9'h100, 32'h50); wr(9'h104, 32'h90); wr(9'h10C, 32'h2);
    push(32'hC0, 1'b0, 0); push(32'hE0, 1'b1, mem[8'h30]);
    copy_exp(32'h50, 32'h90, 2);
    push(32'hC4, 1'b0, 0); push(32'hE4, 1'b1, mem[8'h31]);
    wr(9'h130, 32'h1);
    wr(9'h110, 32'h1);
    hold = 1'b0;
    drain("R4 order drained");
    rd(9'h014, v); chk("R6 no tc without bit31", v, 0);
    rd(9'h130, v); chk("R4 ch1 stopped", v, 0);

    // R5 chain through a descriptor at 0x200
    mem[8'h80] = 32'h60; mem[8'h81] = 32'hA0; mem[8'h82] = 0; mem[8'h83] = 32'h8000_0001;
    stall = 1'b1;
    wr(9'h100, 32'h48); wr(9'h104, 32'h88); wr(9'h108, 32'h200); wr(9'h10C, 32'h1);
    push(32'h48, 1'b0, 0); push(32'h88, 1'b1, mem[8'h12]);
    push(32'h200, 1'b0, 0); push(32'h204, 1'b0, 0);
    push(32'h208, 1'b0, 0); push(32'h20C, 1'b0, 0);
    push(32'h60, 1'b0, 0); push(32'hA0, 1'b1, mem[8'h18]);
    wr(9'h110, 32'h8001);
    drain("R5 chain drained");
    rd(9'h108, v); chk("R5 next loaded", v, 0);
    rd(9'h100, v); chk("R5 src loaded", v, 32'h64);
    rd(9'h104, v); chk("R5 dst loaded", v, 32'hA4);
    rd(9'h110, v); chk("R5 end of chain", v, 32'h8000);
    rd(9'h004, v); chk("R6 second block tc", v, 1);
    wr(9'h008, 32'h1);

    // R7 bus fault on second source read of ch1
    err_on = 1'b1; err_addr = 32'hD4;
    wr(9'h120, 32'hD0); wr(9'h124, 32'hF0); wr(9'h12C, 32'h3);
    push(32'hD0, 1'b0, 0); push(32'hF0, 1'b1, mem[8'h34]); push(32'hD4, 1'b0, 0);
    wr(9'h130, 32'h4001);
    drain("R7 stop after fault");
    rd(9'h018, v); chk("R7 raw err", v, 2);
    rd(9'h00C, v); chk("R7 masked err", v, 2);
    rd(9'h000, v); chk("R9 combined err", v, 2);
    chk("R9 irq err", irq, 1);
    rd(9'h130, v); chk("R7 enable cleared", v, 32'h4000);
    rd(9'h12C, v); chk("R7 count left", v, 2);
    wr(9'h010, 32'h2);
    rd(9'h018, v); chk("R8 err cleared", v, 0);
    chk("R8 irq low after err clear", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule